// File: doc/BRIEF.md
# Atomic Word Access Bridge for a Byte-Wide Bus

This block lets a processor with an 8-bit data bus read and write a set of 16-bit timer words without tearing. The set is a free-running counter, a configurable number of compare words, and a capture word. Each word is reached through two byte addresses. One byte-wide holding register is shared by every word.

A high-byte write only parks the byte in the holding register. The later low-byte write commits the whole word in one clock edge. On the read side, a low-byte read of the counter or the capture word returns the low byte and, on the same edge, copies that word's upper byte into the holding register. The following high-byte read returns that frozen copy, so a counter that keeps running between the two reads still yields a consistent pair. Compare words are read directly, byte by byte, and never use the holding register.

Software must write high then low, and read low then high. Because the holding register is shared, two such sequences to different words must not be interleaved. The block also holds the word registers: the counter step and the capture event come in as inputs, and all words are exposed as 16-bit outputs.

Top module: `wide_reg_bridge`

## Requirements
- R1: After reset every word (counter, each compare, capture) and the holding register are zero.
- R2: A write to a high-byte address (bit 0 of the address = 1) stores the byte in the holding register only; no word changes because of it.
- R3: A write to a low-byte address loads that word with {holding register, written byte} on the same clock edge, visible the cycle after, and leaves the holding register unchanged.
- R4: A read of the low byte of the counter or capture word returns bits 7:0 combinationally, and on that edge copies bits 15:8 of the same word into the holding register.
- R5: A read of the high byte of the counter or capture word returns the holding register, not the live word.
- R6: Reads of either byte of a compare word return that word's bytes directly, and never change the holding register.
- R7: The holding register is shared: a high-byte write to any mapped address replaces it, so a later low-byte write to any word uses the most recent high byte. It changes only on a bus access.
- R8: While the count input is high, the counter steps by one per cycle and wraps from 0xFFFF to 0x0000; a low-byte write to the counter on the same edge wins over the step.
- R9: The capture strobe copies the counter's current value into the capture word on the next edge; a low-byte write to the capture word on the same edge wins over the strobe.
- R10: Addresses past the last word read as 0x00, and writes to them change neither any word nor the holding register.
- R11: Word index is the address shifted right by one: 0 counter, 1 to 3 compare words (default count), 4 capture; with defaults, byte addresses 0 to 9 are mapped.
- R12: With read and write strobes both high, the write takes effect and the read does not update the holding register.
- R13: The read data bus is 0x00 whenever the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Byte address: word index in the upper bits, byte select in bit 0 |
| bus_wdata | input | 8 | Write data byte |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_re | input | 1 | Read strobe, one access per cycle |
| bus_rdata | output | 8 | Read data byte, combinational from address and state |
| cnt_inc | input | 1 | Counter step enable |
| cap_strobe | input | 1 | Capture event: copy counter into capture word |
| cnt_value | output | 16 | Current counter word |
| cmp_value | output | 3x16 | Compare words, element 0 at word index 1 |
| cap_value | output | 16 | Capture word |

## Verification
A corrupted holding register stays hidden until software next completes a pair. It shows as a wrong high byte on the next counter or capture high read in the same cycle, or as a wrong upper byte in whichever word the next low write commits, one cycle later. A bad word value shows on its output port in the cycle after the faulty edge. The bench therefore follows every high write and every low read with the matching second access, and compares all word outputs after every edge. Interleaved sequences and runs with both strobes high are used to expose a holding register that is updated when it should not be.

// File: rtl/wrb_pkg.sv
package wrb_pkg;

   typedef enum logic [1:0] {
      K_COUNTER = 2'd0,
      K_COMPARE = 2'd1,
      K_CAPTURE = 2'd2,
      K_NONE    = 2'd3
   } word_kind_e;

   // Word index 0 is the counter, then the compare words, then capture.
   function automatic word_kind_e kind_of(input int idx, input int n_cmp);
      if (idx == 0)
         return K_COUNTER;
      else if (idx <= n_cmp)
         return K_COMPARE;
      else if (idx == n_cmp + 1)
         return K_CAPTURE;
      else
         return K_NONE;
   endfunction

endpackage

// File: rtl/wrb_decode.sv
module wrb_decode
   import wrb_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int N_CMP  = 3,
   localparam int N_REG = N_CMP + 2,
   localparam int IDX_W = ADDR_W - 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic              re,
   output logic [IDX_W-1:0]  idx,
   output logic              hi_sel,
   output logic              mapped,
   output word_kind_e        kind,
   output logic [N_REG-1:0]  wr_lo,
   output logic              tmp_wr,
   output logic              tmp_snap
);

   assign idx    = addr[ADDR_W-1:1];
   assign hi_sel = addr[0];

   always_comb begin
      kind   = K_NONE;
      mapped = 1'b0;
      for (int i = 0; i < N_REG; i++) begin
         if (idx == IDX_W'(i)) begin
            kind   = kind_of(i, N_CMP);
            mapped = 1'b1;
         end
      end
   end

   // Low-byte write strobe per word.
   genvar g;
   generate
      for (g = 0; g < N_REG; g++) begin : g_wr
         assign wr_lo[g] = we && !hi_sel && (idx == IDX_W'(g));
      end
   endgenerate

   // High-byte writes park the byte; low reads of counter or capture snapshot.
   assign tmp_wr   = we && hi_sel && mapped;
   assign tmp_snap = re && !we && !hi_sel &&
                     ((kind == K_COUNTER) || (kind == K_CAPTURE));

endmodule

// File: rtl/wrb_stage.sv
module wrb_stage #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hi,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              snap,
   input  logic [DATA_W-1:0] snap_data,
   output logic [DATA_W-1:0] tmp
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tmp <= '0;
      else if (wr_hi)
         tmp <= wr_data;
      else if (snap)
         tmp <= snap_data;
   end

endmodule

// File: rtl/wrb_word.sv
module wrb_word #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] load_data,
   input  logic              evt,
   input  logic [WORD_W-1:0] evt_data,
   output logic [WORD_W-1:0] q
);

   // The bus load outranks the word's own event.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (load)
         q <= load_data;
      else if (evt)
         q <= evt_data;
   end

endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
   import wrb_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int N_CMP  = 3,
   parameter int ADDR_W = 4,
   localparam int WORD_W = 2 * DATA_W,
   localparam int N_REG  = N_CMP + 2,
   localparam int IDX_W  = ADDR_W - 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic [DATA_W-1:0]            bus_wdata,
   input  logic                         bus_we,
   input  logic                         bus_re,
   output logic [DATA_W-1:0]            bus_rdata,
   input  logic                         cnt_inc,
   input  logic                         cap_strobe,
   output logic [WORD_W-1:0]            cnt_value,
   output logic [N_CMP-1:0][WORD_W-1:0] cmp_value,
   output logic [WORD_W-1:0]            cap_value
);

   generate
      if (N_CMP < 1) begin : g_bad_cmp
         $error("wide_reg_bridge: N_CMP must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("wide_reg_bridge: DATA_W must be positive");
      end
      if (2 * N_REG > (1 << ADDR_W)) begin : g_bad_addr
         $error("wide_reg_bridge: ADDR_W too small for the word count");
      end
   endgenerate

   logic [IDX_W-1:0]  idx;
   logic              hi_sel;
   logic              mapped;
   word_kind_e        kind;
   logic [N_REG-1:0]  wr_lo;
   logic              tmp_wr;
   logic              tmp_snap;
   logic [DATA_W-1:0] tmp_q;
   logic [WORD_W-1:0] words [N_REG];
   logic [WORD_W-1:0] sel_word;

   wrb_decode #(
      .ADDR_W (ADDR_W),
      .N_CMP  (N_CMP)
   ) u_decode (
      .addr     (bus_addr),
      .we       (bus_we),
      .re       (bus_re),
      .idx      (idx),
      .hi_sel   (hi_sel),
      .mapped   (mapped),
      .kind     (kind),
      .wr_lo    (wr_lo),
      .tmp_wr   (tmp_wr),
      .tmp_snap (tmp_snap)
   );

   always_comb begin
      sel_word = '0;
      for (int i = 0; i < N_REG; i++) begin
         if (idx == IDX_W'(i))
            sel_word = words[i];
      end
   end

   wrb_stage #(
      .DATA_W (DATA_W)
   ) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_hi     (tmp_wr),
      .wr_data   (bus_wdata),
      .snap      (tmp_snap),
      .snap_data (sel_word[WORD_W-1:DATA_W]),
      .tmp       (tmp_q)
   );

   // Each word's event source depends on its kind.
   genvar g;
   generate
      for (g = 0; g < N_REG; g++) begin : g_word
         logic              evt;
         logic [WORD_W-1:0] evt_data;
         if (kind_of(g, N_CMP) == K_COUNTER) begin : g_cnt
            assign evt      = cnt_inc;
            assign evt_data = words[g] + WORD_W'(1);
         end else if (kind_of(g, N_CMP) == K_CAPTURE) begin : g_cap
            assign evt      = cap_strobe;
            assign evt_data = words[0];
         end else begin : g_plain
            assign evt      = 1'b0;
            assign evt_data = '0;
         end
         wrb_word #(
            .WORD_W (WORD_W)
         ) u_word (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (wr_lo[g]),
            .load_data ({tmp_q, bus_wdata}),
            .evt       (evt),
            .evt_data  (evt_data),
            .q         (words[g])
         );
      end
      for (g = 0; g < N_CMP; g++) begin : g_cmp_out
         assign cmp_value[g] = words[g+1];
      end
   endgenerate

   assign cnt_value = words[0];
   assign cap_value = words[N_REG-1];

   always_comb begin
      bus_rdata = '0;
      if (bus_re && mapped) begin
         if (!hi_sel)
            bus_rdata = sel_word[DATA_W-1:0];
         else if (kind == K_COMPARE)
            bus_rdata = sel_word[WORD_W-1:DATA_W];
         else
            bus_rdata = tmp_q;
      end
   end

endmodule

// File: rtl/wrb_checker.sv
module wrb_checker #(
   parameter int DATA_W = 8,
   parameter int N_CMP  = 3,
   parameter int ADDR_W = 4,
   localparam int WORD_W = 2 * DATA_W,
   localparam int N_REG  = N_CMP + 2
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [ADDR_W-1:0]            bus_addr,
   input logic [DATA_W-1:0]            bus_wdata,
   input logic                         bus_we,
   input logic                         bus_re,
   input logic [DATA_W-1:0]            bus_rdata,
   input logic                         cnt_inc,
   input logic                         cap_strobe,
   input logic [WORD_W-1:0]            cnt_value,
   input logic [N_CMP-1:0][WORD_W-1:0] cmp_value,
   input logic [WORD_W-1:0]            cap_value,
   input logic [DATA_W-1:0]            tmp
);

   localparam logic [ADDR_W-1:0] A_CNT_LO = '0;
   localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_CMP_HI = ADDR_W'(3);
   localparam logic [ADDR_W-1:0] A_CAP_LO = ADDR_W'(2 * (N_REG - 1));

   logic [ADDR_W-2:0] c_idx;
   logic              c_is_cmp;
   logic              c_unmapped;
   assign c_idx      = bus_addr[ADDR_W-1:1];
   assign c_is_cmp   = (int'(c_idx) >= 1) && (int'(c_idx) <= N_CMP);
   assign c_unmapped = int'(c_idx) >= N_REG;

   // R2: a high-byte write alone leaves the compare and capture words untouched
   p_hi_write_keeps_words_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr[0] && !cap_strobe) |=> ($stable(cmp_value) && $stable(cap_value)));

   // R3 and R8: counter low write commits {holding, byte} even while counting
   p_lo_write_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_CNT_LO) |=> (cnt_value == {$past(tmp), $past(bus_wdata)}));

   // R4: counter low read snapshots its upper byte
   p_lo_read_snap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && !bus_we && bus_addr == A_CNT_LO) |=> (tmp == $past(cnt_value[WORD_W-1:DATA_W])));

   // R5: counter high read returns the holding register
   p_hi_read_holding_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && bus_addr == A_CNT_HI) |-> (bus_rdata == tmp));

   // R6: compare high read is direct
   p_cmp_read_direct_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && bus_addr == A_CMP_HI) |-> (bus_rdata == cmp_value[0][WORD_W-1:DATA_W]));

   // R6: compare reads never touch the holding register
   p_cmp_read_keeps_tmp_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && !bus_we && c_is_cmp) |=> $stable(tmp));

   // R7: holding register moves only on a bus access
   p_tmp_idle_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_we && !bus_re) |=> $stable(tmp));

   // R8: counter steps by one when enabled and not written
   p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_inc && !(bus_we && bus_addr == A_CNT_LO)) |=> (cnt_value == WORD_W'($past(cnt_value) + 1'b1)));

   // R9: capture strobe copies the counter
   p_capture_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_strobe && !(bus_we && bus_addr == A_CAP_LO)) |=> (cap_value == $past(cnt_value)));

   // R10: unmapped reads return zero
   p_unmapped_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && c_unmapped) |-> (bus_rdata == '0));

   // R12: a low access with both strobes leaves the holding register alone
   p_both_strobes_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_re && !bus_addr[0]) |=> $stable(tmp));

   // R13: idle read bus
   p_rdata_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_re |-> (bus_rdata == '0));

endmodule

bind wide_reg_bridge wrb_checker #(
   .DATA_W (DATA_W),
   .N_CMP  (N_CMP),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .bus_we     (bus_we),
   .bus_re     (bus_re),
   .bus_rdata  (bus_rdata),
   .cnt_inc    (cnt_inc),
   .cap_strobe (cap_strobe),
   .cnt_value  (cnt_value),
   .cmp_value  (cmp_value),
   .cap_value  (cap_value),
   .tmp        (tmp_q)
);

// File: tb/tb_wide_reg_bridge.sv
`timescale 1ns/1ps
module tb_wide_reg_bridge;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [3:0]        bus_addr;
   logic [7:0]        bus_wdata;
   logic              bus_we;
   logic              bus_re;
   logic [7:0]        bus_rdata;
   logic              cnt_inc;
   logic              cap_strobe;
   logic [15:0]       cnt_value;
   logic [2:0][15:0]  cmp_value;
   logic [15:0]       cap_value;

   always #2.5 clk = ~clk;

   wide_reg_bridge dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_we     (bus_we),
      .bus_re     (bus_re),
      .bus_rdata  (bus_rdata),
      .cnt_inc    (cnt_inc),
      .cap_strobe (cap_strobe),
      .cnt_value  (cnt_value),
      .cmp_value  (cmp_value),
      .cap_value  (cap_value)
   );

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;
   bit done   = 0;
   int m_reg [5];
   int m_tmp;

   task automatic check(input string tag, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic int exp_rdata(input bit re, input int a);
      int idx = a >> 1;
      bit hi  = a[0];
      if (!re || idx > 4) return 0;
      if (!hi) return m_reg[idx] & 255;
      if (idx >= 1 && idx <= 3) return (m_reg[idx] >> 8) & 255;
      return m_tmp;
   endfunction

   task automatic check_words(input string tag);
      check(tag, "counter", cnt_value, 16'(m_reg[0]));
      for (int i = 0; i < 3; i++)
         check(tag, "compare", cmp_value[i], 16'(m_reg[i+1]));
      check(tag, "capture", cap_value, 16'(m_reg[4]));
   endtask

   // One bus cycle: drive at the falling edge, check read data, step the model.
   task automatic step(input bit we, input bit re, input int a, input int d,
                       input bit inc, input bit cap, input string tag);
      int idx;
      bit hi;
      bit mapped;
      int nxt [5];
      int ntmp;
      @(negedge clk);
      bus_we = we; bus_re = re; bus_addr = 4'(a); bus_wdata = 8'(d);
      cnt_inc = inc; cap_strobe = cap;
      #1;
      check(tag, "rdata", {8'h00, bus_rdata}, 16'(exp_rdata(re, a)));
      idx = a >> 1;
      hi = a[0];
      mapped = (idx <= 4);
      for (int i = 0; i < 5; i++) nxt[i] = m_reg[i];
      ntmp = m_tmp;
      if (inc) nxt[0] = (m_reg[0] + 1) & 16'hFFFF;
      if (cap) nxt[4] = m_reg[0];
      if (we && mapped && !hi) nxt[idx] = ((m_tmp << 8) | d) & 16'hFFFF;
      if (we && mapped && hi) ntmp = d;
      else if (!we && re && mapped && !hi && (idx == 0 || idx == 4))
         ntmp = (m_reg[idx] >> 8) & 255;
      @(posedge clk);
      for (int i = 0; i < 5; i++) m_reg[i] = nxt[i];
      m_tmp = ntmp;
      #1;
      check_words(tag);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      bus_we = 0; bus_re = 0; bus_addr = '0; bus_wdata = '0;
      cnt_inc = 0; cap_strobe = 0;
      for (int i = 0; i < 5; i++) m_reg[i] = 0;
      m_tmp = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check_words("R1");
      step(0, 1, 1, 0, 0, 0, "R1");        // holding reg is zero
      step(0, 0, 0, 0, 0, 0, "R13");       // idle read bus

      // R2/R3: compare word via high then low, R11 map
      step(1, 0, 3, 8'h12, 0, 0, "R2");
      step(1, 0, 2, 8'h34, 0, 0, "R3");
      step(0, 1, 2, 0, 0, 0, "R6");
      step(0, 1, 3, 0, 0, 0, "R6");
      step(0, 1, 1, 0, 0, 0, "R6");        // still 0x12 after compare reads

      // R4/R5: counter read is atomic while counting
      step(1, 0, 1, 8'h00, 0, 0, "R2");
      step(1, 0, 0, 8'hFE, 0, 0, "R3");
      step(0, 0, 0, 0, 1, 0, "R8");
      step(0, 1, 0, 0, 1, 0, "R4");
      step(0, 1, 1, 0, 1, 0, "R5");
      step(0, 1, 0, 0, 1, 0, "R4");
      step(0, 1, 1, 0, 0, 0, "R5");

      // R8: write wins over step; wrap
      step(1, 0, 1, 8'h55, 1, 0, "R8");
      step(1, 0, 0, 8'hAA, 1, 0, "R8");
      step(1, 0, 1, 8'hFF, 0, 0, "R8");
      step(1, 0, 0, 8'hFF, 0, 0, "R8");
      step(0, 0, 0, 0, 1, 0, "R8");
      step(0, 0, 0, 0, 1, 0, "R8");

      // R7: interleaved high writes share the holding register
      step(1, 0, 5, 8'h77, 0, 0, "R7");
      step(1, 0, 7, 8'h99, 0, 0, "R7");
      step(1, 0, 4, 8'h01, 0, 0, "R7");
      step(1, 0, 6, 8'h02, 0, 0, "R7");
      step(0, 1, 5, 0, 0, 0, "R7");

      // R9: capture strobe and write priority
      for (int k = 0; k < 5; k++) step(0, 0, 0, 0, 1, 0, "R9");
      step(0, 0, 0, 0, 1, 1, "R9");
      step(1, 0, 9, 8'hAB, 1, 0, "R9");
      step(1, 0, 8, 8'hCD, 1, 1, "R9");
      step(0, 1, 8, 0, 0, 0, "R4");
      step(0, 1, 9, 0, 0, 0, "R5");

      // R10: unmapped addresses
      step(1, 0, 11, 8'hEE, 0, 0, "R10");
      step(1, 0, 10, 8'h5A, 0, 0, "R10");
      step(1, 0, 15, 8'h11, 0, 0, "R10");
      step(0, 1, 10, 0, 0, 0, "R10");
      step(0, 1, 13, 0, 0, 0, "R10");
      step(0, 1, 1, 0, 0, 0, "R10");       // holding still 0xAB

      // R12: both strobes on a low capture access
      step(1, 0, 1, 8'h3C, 0, 0, "R12");
      step(1, 1, 8, 8'h11, 0, 0, "R12");
      step(0, 1, 1, 0, 0, 0, "R12");
      step(1, 1, 2, 8'h44, 0, 0, "R12");
      step(0, 1, 9, 0, 0, 0, "R12");

      // R11: walk every mapped byte address
      for (int a = 0; a < 10; a++) step(0, 1, a, 0, 0, 0, "R11");
      step(0, 0, 0, 0, 0, 0, "R13");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule